// File: doc/BRIEF.md
# Test-access instruction register and decoder

This block holds the 8-bit instruction of an IEEE 1149.1 test access port and turns it into the controls used by the rest of the test logic. A TAP state machine outside the block supplies one strobe per state of interest: test-logic-reset, capture-IR, shift-IR, update-IR, capture-DR and shift-DR. The block uses these strobes to capture a fixed pattern into a shift stage, shift instruction bits from `tdi` towards `tdo`, and copy the shift stage into the active instruction on update.

The active instruction is decoded into a one-hot choice of data register and two output-mode controls. The data register is one of: the full boundary chain, its input half, its output half, the one-bit bypass stage, or the 32-bit identification register. The output modes are "pads take their values from the boundary cells" and "every output enable is forced off". The bypass stage and the identification register are built into this block. The boundary chain is not: its serial output arrives on `bnd_so`. The captured pattern is the sample/preload opcode. So the path capture-IR, exit, update-IR selects sample/preload without any shifting.

Serial output is launched on the falling edge of `tck` and is enabled only while the controller is in a shift state. All other registers change on the rising edge. The reset input acts at once when asserted but is released in step with `tck`.

Top module: `jtag_ir_decode`

## Requirements
- R1: While `trst_n` is low, and on every rising edge with `st_tlr` high, the active instruction becomes IDCODE (8'hAA), so `sel_idcode` is high. When `HAS_ID` is 0 it becomes BYPASS (8'hFF) instead.
- R2: A rising edge with `st_cap_ir` high loads 8'h81 (sample/preload) into the shift stage. A following update with no shifting selects the full boundary chain with both modes low.
- R3: Each rising edge with `st_shift_ir` high moves the shift stage one place towards bit 0. `tdi` enters bit 7 and bit 0 is presented on `tdo`. Shifting never changes the decoded outputs; only a rising edge with `st_upd_ir` high copies the shift stage into the active instruction.
- R4: Boundary opcodes decode as follows. 8'h00 selects the full chain with `mode_drive`. 8'h81 selects the full chain alone. 8'h41 selects the input half. 8'h42 selects the output half. 8'h22 selects the output half with `mode_drive`.
- R5: 8'h82 selects bypass with `mode_drive` high. 8'h03 selects bypass with `mode_hiz` high. `mode_hiz` is never high together with `mode_drive`.
- R6: 8'hAA selects the identification register. 8'hFF, and every byte not listed in R4, R5 or R6, selects bypass with both modes low.
- R7: Exactly one of the five select outputs is high at all times.
- R8: With bypass selected, capture-DR loads 0 into the bypass stage and shift-DR moves `tdi` through it. A bit on `tdi` therefore appears on `tdo` one shift later.
- R9: With the identification register selected, capture-DR loads {version 4'h0, part 16'h5A3C, maker 11'h1D3, 1'b1}. Shift-DR then shifts it out least significant bit first.
- R10: With any boundary select high, `tdo` during shift-DR carries `bnd_so` as sampled at the falling edge.
- R11: `tdo` and `tdo_en` change only on falling edges of `tck`. `tdo_en` is high only when the edge saw `st_shift_ir` or `st_shift_dr`; otherwise `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset, released on `tck` |
| tdi | input | 1 | Serial test data in |
| st_tlr | input | 1 | Controller is in test-logic-reset |
| st_cap_ir | input | 1 | Controller is in capture-IR |
| st_shift_ir | input | 1 | Controller is in shift-IR |
| st_upd_ir | input | 1 | Controller is in update-IR |
| st_cap_dr | input | 1 | Controller is in capture-DR |
| st_shift_dr | input | 1 | Controller is in shift-DR |
| bnd_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out, falling-edge launched |
| tdo_en | output | 1 | High while `tdo` is actively driven |
| sel_bnd_full | output | 1 | Full boundary chain selected |
| sel_bnd_in | output | 1 | Input half of the boundary chain selected |
| sel_bnd_out | output | 1 | Output half of the boundary chain selected |
| sel_bypass | output | 1 | Bypass stage selected |
| sel_idcode | output | 1 | Identification register selected |
| mode_drive | output | 1 | Pads take values from boundary cells |
| mode_hiz | output | 1 | All output enables forced inactive |

## Verification
The bench builds the block with its defaults: `HAS_ID` at 1 and the stated identification fields. With these values the reset opcode, the 32-bit captured word and its bit order can all be observed through `tdo`. At this setting every listed opcode is loaded, along with several unlisted bytes, and each one's select and mode pattern is compared with a behavioural model on every cycle. Because the identification register is fitted, the model also reaches the capture-then-update shortcut, the hold of the decode while shifting without an update, and the one-stage delay of the bypass path.

// File: rtl/jtag_ir_pkg.sv
package jtag_ir_pkg;
  localparam int IR_W = 8;
  localparam int ID_W = 32;

  typedef logic [IR_W-1:0] ir_op_t;

  localparam ir_op_t OP_EXTEST   = 8'h00;
  localparam ir_op_t OP_SAMPLE   = 8'h81;
  localparam ir_op_t OP_CLAMP    = 8'h82;
  localparam ir_op_t OP_HIGHZ    = 8'h03;
  localparam ir_op_t OP_SAMP_IN  = 8'h41;
  localparam ir_op_t OP_SAMP_OUT = 8'h42;
  localparam ir_op_t OP_EXT_OUT  = 8'h22;
  localparam ir_op_t OP_IDCODE   = 8'hAA;
  localparam ir_op_t OP_BYPASS   = 8'hFF;

  // value loaded into the shift stage on capture-IR
  localparam ir_op_t IR_CAPTURE  = OP_SAMPLE;

  typedef enum logic [2:0] {
    DR_BND_FULL,
    DR_BND_IN,
    DR_BND_OUT,
    DR_BYPASS,
    DR_ID
  } dr_sel_e;

  typedef struct packed {
    dr_sel_e dr;
    logic    drive;
    logic    hiz;
  } ir_dec_t;
endpackage

// File: rtl/jtag_rst_sync.sv
module jtag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/jtag_ir_shift.sv
module jtag_ir_shift
  import jtag_ir_pkg::*;
#(
  parameter ir_op_t RST_OP = OP_IDCODE
) (
  input  logic   tck,
  input  logic   rst_n,
  input  logic   tdi,
  input  logic   st_tlr,
  input  logic   st_cap,
  input  logic   st_shift,
  input  logic   st_upd,
  output ir_op_t sh,
  output ir_op_t act,
  output logic   so
);
  ir_op_t sh_q, sh_d, act_q, act_d;
  logic   sh_en, act_en;

  always_comb begin
    sh_en = st_cap | st_shift;
    sh_d  = st_cap ? IR_CAPTURE : {tdi, sh_q[IR_W-1:1]};
  end

  always_comb begin
    act_en = st_tlr | st_upd;
    act_d  = st_tlr ? RST_OP : sh_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= IR_CAPTURE;
      act_q <= RST_OP;
    end else begin
      if (sh_en)  sh_q  <= sh_d;
      if (act_en) act_q <= act_d;
    end
  end

  assign sh  = sh_q;
  assign act = act_q;
  assign so  = sh_q[0];
endmodule

// File: rtl/jtag_ir_dec.sv
module jtag_ir_dec
  import jtag_ir_pkg::*;
#(
  parameter bit HAS_ID = 1'b1
) (
  input  ir_op_t  op,
  output ir_dec_t dec
);
  always_comb begin
    dec = '{dr: DR_BYPASS, drive: 1'b0, hiz: 1'b0};
    unique case (op)
      OP_EXTEST:   dec = '{dr: DR_BND_FULL, drive: 1'b1, hiz: 1'b0};
      OP_SAMPLE:   dec = '{dr: DR_BND_FULL, drive: 1'b0, hiz: 1'b0};
      OP_CLAMP:    dec = '{dr: DR_BYPASS,   drive: 1'b1, hiz: 1'b0};
      OP_HIGHZ:    dec = '{dr: DR_BYPASS,   drive: 1'b0, hiz: 1'b1};
      OP_SAMP_IN:  dec = '{dr: DR_BND_IN,   drive: 1'b0, hiz: 1'b0};
      OP_SAMP_OUT: dec = '{dr: DR_BND_OUT,  drive: 1'b0, hiz: 1'b0};
      OP_EXT_OUT:  dec = '{dr: DR_BND_OUT,  drive: 1'b1, hiz: 1'b0};
      OP_IDCODE:   dec = '{dr: (HAS_ID ? DR_ID : DR_BYPASS), drive: 1'b0, hiz: 1'b0};
      default:     dec = '{dr: DR_BYPASS,   drive: 1'b0, hiz: 1'b0};
    endcase
  end
endmodule

// File: rtl/jtag_dr_fixed.sv
module jtag_dr_fixed
  import jtag_ir_pkg::*;
#(
  parameter bit              HAS_ID  = 1'b1,
  parameter logic [ID_W-1:0] ID_WORD = 32'h0000_0001
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tdi,
  input  logic st_cap,
  input  logic st_shift,
  input  logic sel_byp,
  input  logic sel_id,
  output logic byp_q,
  output logic id_so
);
  logic byp_d, byp_en;

  always_comb begin
    byp_en = sel_byp & (st_cap | st_shift);
    byp_d  = st_cap ? 1'b0 : tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  generate
    if (HAS_ID) begin : g_id
      logic [ID_W-1:0] id_q, id_d;
      logic            id_en;

      always_comb begin
        id_en = sel_id & (st_cap | st_shift);
        id_d  = st_cap ? ID_WORD : {tdi, id_q[ID_W-1:1]};
      end

      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)     id_q <= ID_WORD;
        else if (id_en) id_q <= id_d;
      end

      assign id_so = id_q[0];
    end else begin : g_no_id
      assign id_so = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
  import jtag_ir_pkg::*;
#(
  parameter bit          HAS_ID     = 1'b1,
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [15:0] ID_PART    = 16'h5A3C,
  parameter logic [10:0] ID_MAKER   = 11'h1D3
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic st_tlr,
  input  logic st_cap_ir,
  input  logic st_shift_ir,
  input  logic st_upd_ir,
  input  logic st_cap_dr,
  input  logic st_shift_dr,
  input  logic bnd_so,
  output logic tdo,
  output logic tdo_en,
  output logic sel_bnd_full,
  output logic sel_bnd_in,
  output logic sel_bnd_out,
  output logic sel_bypass,
  output logic sel_idcode,
  output logic mode_drive,
  output logic mode_hiz
);
  localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};
  localparam ir_op_t          RST_OP  = HAS_ID ? OP_IDCODE : OP_BYPASS;

  logic    rst_n;
  ir_op_t  ir_sh, ir_act;
  logic    ir_so, byp_q, id_so;
  ir_dec_t dec;
  logic    ser_mux, tdo_d, tdo_en_d, tdo_q, tdo_en_q;

  jtag_rst_sync #(.STAGES(2)) u_rst (
    .clk(tck), .arst_n(trst_n), .rst_n(rst_n)
  );

  jtag_ir_shift #(.RST_OP(RST_OP)) u_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi),
    .st_tlr(st_tlr), .st_cap(st_cap_ir), .st_shift(st_shift_ir), .st_upd(st_upd_ir),
    .sh(ir_sh), .act(ir_act), .so(ir_so)
  );

  jtag_ir_dec #(.HAS_ID(HAS_ID)) u_dec (.op(ir_act), .dec(dec));

  assign sel_bnd_full = (dec.dr == DR_BND_FULL);
  assign sel_bnd_in   = (dec.dr == DR_BND_IN);
  assign sel_bnd_out  = (dec.dr == DR_BND_OUT);
  assign sel_bypass   = (dec.dr == DR_BYPASS);
  assign sel_idcode   = (dec.dr == DR_ID);
  assign mode_drive   = dec.drive;
  assign mode_hiz     = dec.hiz;

  jtag_dr_fixed #(.HAS_ID(HAS_ID), .ID_WORD(ID_WORD)) u_dr (
    .tck(tck), .rst_n(rst_n), .tdi(tdi),
    .st_cap(st_cap_dr), .st_shift(st_shift_dr),
    .sel_byp(sel_bypass), .sel_id(sel_idcode),
    .byp_q(byp_q), .id_so(id_so)
  );

  // serial source for the current state
  always_comb begin
    unique case (dec.dr)
      DR_BYPASS: ser_mux = byp_q;
      DR_ID:     ser_mux = id_so;
      default:   ser_mux = bnd_so;
    endcase
    tdo_en_d = st_shift_ir | st_shift_dr;
    if (st_shift_ir)      tdo_d = ir_so;
    else if (st_shift_dr) tdo_d = ser_mux;
    else                  tdo_d = 1'b0;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_d;
      tdo_en_q <= tdo_en_d;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_en = tdo_en_q;
endmodule

// File: rtl/jtag_ir_decode_chk.sv
module jtag_ir_decode_chk
  import jtag_ir_pkg::*;
#(
  parameter bit HAS_ID = 1'b1
) (
  input logic   tck,
  input logic   rst_n,
  input logic   st_tlr,
  input logic   st_cap_ir,
  input logic   st_shift_ir,
  input logic   st_upd_ir,
  input logic   st_cap_dr,
  input logic   st_shift_dr,
  input ir_op_t ir_sh,
  input ir_op_t ir_act,
  input logic   byp_q,
  input logic   tdo_en,
  input logic   sel_bnd_full,
  input logic   sel_bnd_in,
  input logic   sel_bnd_out,
  input logic   sel_bypass,
  input logic   sel_idcode,
  input logic   mode_drive,
  input logic   mode_hiz
);
  // R1: reset state returns the identification (or bypass) instruction
  a_r1_tlr_reload: assert property (@(posedge tck) disable iff (!rst_n)
    st_tlr |=> (HAS_ID ? sel_idcode : sel_bypass));

  // R2: capture-IR loads the sample/preload pattern
  a_r2_capture: assert property (@(posedge tck) disable iff (!rst_n)
    st_cap_ir |=> (ir_sh == OP_SAMPLE));

  // R3: active instruction changes only through update or reset
  a_r3_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (!st_tlr && !st_upd_ir) |=> $stable(ir_act));

  // R5: high impedance mode only with bypass, never with drive
  a_r5_hiz_alone: assert property (@(posedge tck) disable iff (!rst_n)
    mode_hiz |-> (sel_bypass && !mode_drive));

  // R7: one data register selected
  a_r7_one_select: assert property (@(posedge tck) disable iff (!rst_n)
    $countones({sel_bnd_full, sel_bnd_in, sel_bnd_out, sel_bypass, sel_idcode}) == 1);

  // R8: bypass captures zero
  a_r8_bypass_zero: assert property (@(posedge tck) disable iff (!rst_n)
    (st_cap_dr && sel_bypass) |=> !byp_q);

  // R11: output enable follows the shift states seen at the falling edge
  a_r11_enable: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == (st_shift_ir || st_shift_dr));
endmodule

bind jtag_ir_decode jtag_ir_decode_chk #(.HAS_ID(HAS_ID)) u_chk (
  .tck(tck), .rst_n(rst_n),
  .st_tlr(st_tlr), .st_cap_ir(st_cap_ir), .st_shift_ir(st_shift_ir),
  .st_upd_ir(st_upd_ir), .st_cap_dr(st_cap_dr), .st_shift_dr(st_shift_dr),
  .ir_sh(ir_sh), .ir_act(ir_act), .byp_q(byp_q), .tdo_en(tdo_en),
  .sel_bnd_full(sel_bnd_full), .sel_bnd_in(sel_bnd_in), .sel_bnd_out(sel_bnd_out),
  .sel_bypass(sel_bypass), .sel_idcode(sel_idcode),
  .mode_drive(mode_drive), .mode_hiz(mode_hiz)
);

// File: tb/jtag_ir_decode_tb.sv
`timescale 1ns/1ps
module jtag_ir_decode_tb;
  localparam logic [31:0] EXP_ID = {4'h0, 16'h5A3C, 11'h1D3, 1'b1};
  localparam logic [5:0] S_IDLE = 6'b000000, S_TLR = 6'b000001, S_CIR = 6'b000010,
                         S_SIR  = 6'b000100, S_UIR = 6'b001000, S_CDR = 6'b010000,
                         S_SDR  = 6'b100000;

  logic tck = 1'b0;
  logic trst_n, tdi, bnd_so;
  logic [5:0] stb;
  logic tdo, tdo_en, sel_bnd_full, sel_bnd_in, sel_bnd_out, sel_bypass, sel_idcode;
  logic mode_drive, mode_hiz;

  integer checks = 0, errors = 0;
  bit     done = 0;

  always #4 tck = ~tck;

  jtag_ir_decode u_dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .st_tlr(stb[0]), .st_cap_ir(stb[1]), .st_shift_ir(stb[2]), .st_upd_ir(stb[3]),
    .st_cap_dr(stb[4]), .st_shift_dr(stb[5]), .bnd_so(bnd_so),
    .tdo(tdo), .tdo_en(tdo_en),
    .sel_bnd_full(sel_bnd_full), .sel_bnd_in(sel_bnd_in), .sel_bnd_out(sel_bnd_out),
    .sel_bypass(sel_bypass), .sel_idcode(sel_idcode),
    .mode_drive(mode_drive), .mode_hiz(mode_hiz)
  );

  // ---------------- behavioural reference ----------------
  // decode vector: {full, in, out, bypass, id, drive, hiz}
  function automatic logic [6:0] ref_dec(input logic [7:0] op);
    case (op)
      8'h00:   return 7'b1000010;
      8'h81:   return 7'b1000000;
      8'h82:   return 7'b0001010;
      8'h03:   return 7'b0001001;
      8'h41:   return 7'b0100000;
      8'h42:   return 7'b0010000;
      8'h22:   return 7'b0010010;
      8'hAA:   return 7'b0000100;
      default: return 7'b0001000;
    endcase
  endfunction

  integer     m_live;
  logic [7:0] m_sh, m_act;
  logic       m_byp, m_tdo, m_en;
  bit         m_idq[$];

  task automatic m_reset();
    m_sh = 8'h81; m_act = 8'hAA; m_byp = 1'b0;
    m_idq.delete();
    for (int i = 0; i < 32; i++) m_idq.push_back(EXP_ID[i]);
  endtask

  always @(posedge tck) begin
    logic [6:0] d;
    if (!trst_n) begin
      m_live = 0; m_reset();
    end else if (m_live < 2) begin
      m_live = m_live + 1; m_reset();
    end else begin
      d = ref_dec(m_act);
      if (stb[4] && d[3]) m_byp = 1'b0;
      else if (stb[5] && d[3]) m_byp = tdi;
      if (stb[4] && d[2]) begin
        m_idq.delete();
        for (int i = 0; i < 32; i++) m_idq.push_back(EXP_ID[i]);
      end else if (stb[5] && d[2]) begin
        void'(m_idq.pop_front());
        m_idq.push_back(tdi);
      end
      if (stb[0]) m_act = 8'hAA;
      else if (stb[3]) m_act = m_sh;
      if (stb[1]) m_sh = 8'h81;
      else if (stb[2]) m_sh = {tdi, m_sh[7:1]};
    end
  end

  always @(negedge tck) begin
    logic [6:0] d;
    d = ref_dec(m_act);
    if (!trst_n || m_live < 2) begin
      m_tdo = 1'b0; m_en = 1'b0;
    end else begin
      m_en = stb[2] | stb[5];
      if (stb[2])      m_tdo = m_sh[0];
      else if (stb[5]) m_tdo = d[3] ? m_byp : (d[2] ? m_idq[0] : bnd_so);
      else             m_tdo = 1'b0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [6:0] dut_dec();
    return {sel_bnd_full, sel_bnd_in, sel_bnd_out, sel_bypass, sel_idcode, mode_drive, mode_hiz};
  endfunction

  logic early_tdo;

  task automatic cyc(input logic [5:0] s, input logic d);
    @(posedge tck);
    #1 stb = s; tdi = d; bnd_so = 1'($urandom);
    #1 early_tdo = tdo;
    #4;
    chk("R7 decode vs model", {25'd0, dut_dec()}, {25'd0, ref_dec(m_act)});
    chk("R11 tdo_en vs model", {31'd0, tdo_en}, {31'd0, m_en});
    chk("R10 tdo vs model", {31'd0, tdo}, {31'd0, m_tdo});
  endtask

  logic [7:0]  ir_out;
  logic [31:0] dr_out;

  task automatic shift_ir_only(input logic [7:0] op);
    cyc(S_CIR, 1'b0);
    for (int i = 0; i < 8; i++) begin
      cyc(S_SIR, op[i]);
      ir_out[i] = tdo;
    end
    cyc(S_IDLE, 1'b0);
  endtask

  task automatic load_ir(input logic [7:0] op);
    shift_ir_only(op);
    cyc(S_UIR, 1'b0);
    cyc(S_IDLE, 1'b0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    trst_n = 1'b0; stb = S_TLR; tdi = 1'b0; bnd_so = 1'b0;
    repeat (3) cyc(S_TLR, 1'b0);
    chk("R1 reset selects id", {25'd0, dut_dec()}, 32'b0000100);
    chk("R11 reset tdo_en low", {31'd0, tdo_en}, 32'd0);
    trst_n = 1'b1;
    repeat (4) cyc(S_TLR, 1'b0);
    chk("R1 after reset release", {25'd0, dut_dec()}, 32'b0000100);

    // R9: identification readout
    cyc(S_CDR, 1'b0);
    for (int i = 0; i < 32; i++) begin
      cyc(S_SDR, 1'b0);
      dr_out[i] = tdo;
    end
    cyc(S_IDLE, 1'b0);
    chk("R9 id word", dr_out, EXP_ID);
    chk("R11 tdo_en released", {31'd0, tdo_en}, 32'd0);

    // R2: capture then update without shift
    cyc(S_CIR, 1'b0); cyc(S_IDLE, 1'b0); cyc(S_UIR, 1'b0); cyc(S_IDLE, 1'b0);
    chk("R2 capture shortcut selects full chain", {25'd0, dut_dec()}, 32'b1000000);

    load_ir(8'h00);
    chk("R2 captured pattern on tdo", {24'd0, ir_out}, 32'h81);
    chk("R4 extest", {25'd0, dut_dec()}, 32'b1000010);
    load_ir(8'h81); chk("R4 sample", {25'd0, dut_dec()}, 32'b1000000);
    load_ir(8'h41); chk("R4 input half", {25'd0, dut_dec()}, 32'b0100000);
    load_ir(8'h42); chk("R4 output half", {25'd0, dut_dec()}, 32'b0010000);
    load_ir(8'h22); chk("R4 output half drive", {25'd0, dut_dec()}, 32'b0010010);
    load_ir(8'h82); chk("R5 clamp", {25'd0, dut_dec()}, 32'b0001010);
    load_ir(8'h03); chk("R5 high-z", {25'd0, dut_dec()}, 32'b0001001);
    load_ir(8'hAA); chk("R6 idcode", {25'd0, dut_dec()}, 32'b0000100);
    load_ir(8'hFF); chk("R6 bypass", {25'd0, dut_dec()}, 32'b0001000);
    load_ir(8'h5A); chk("R6 unlisted 5A", {25'd0, dut_dec()}, 32'b0001000);
    load_ir(8'h01); chk("R6 unlisted 01", {25'd0, dut_dec()}, 32'b0001000);
    load_ir(8'hC3); chk("R6 unlisted C3", {25'd0, dut_dec()}, 32'b0001000);

    // R8: bypass delay of one stage
    begin
      logic [7:0] pat = 8'b10110010;
      load_ir(8'hFF);
      cyc(S_CDR, 1'b1);
      for (int i = 0; i < 8; i++) begin
        cyc(S_SDR, pat[i]);
        dr_out[i] = tdo;
      end
      chk("R8 bypass first bit zero", {31'd0, dr_out[0]}, 32'd0);
      chk("R8 bypass delay", {25'd0, dr_out[7:1]}, {25'd0, pat[6:0]});
      cyc(S_IDLE, 1'b0);
    end

    // R10, R11: boundary path and falling-edge launch
    load_ir(8'h41);
    cyc(S_CDR, 1'b0);
    for (int i = 0; i < 10; i++) begin
      logic prev;
      prev = tdo;
      cyc(S_SDR, 1'b0);
      chk("R10 tdo carries bnd_so", {31'd0, tdo}, {31'd0, bnd_so});
      chk("R11 tdo held until falling edge", {31'd0, early_tdo}, {31'd0, prev});
    end
    cyc(S_IDLE, 1'b0);

    // R3: shifting without update keeps decode
    load_ir(8'h81);
    shift_ir_only(8'hAA);
    chk("R3 decode held while not updated", {25'd0, dut_dec()}, 32'b1000000);
    cyc(S_UIR, 1'b0); cyc(S_IDLE, 1'b0);
    chk("R3 update applies shifted opcode", {25'd0, dut_dec()}, 32'b0000100);

    // R1: test-logic-reset mid-session
    load_ir(8'h03);
    cyc(S_TLR, 1'b0); cyc(S_IDLE, 1'b0);
    chk("R1 tlr reloads idcode", {25'd0, dut_dec()}, 32'b0000100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule